// File: doc/BRIEF.md
# Single-Select SPI Word Master

This block is a serial-peripheral master that moves one 8-bit or 16-bit word at a time with one attached slave. Software controls it through five 32-bit registers on a simple request/acknowledge bus. One control bit drives the chip-select line directly, so software decides when the slave is selected. A configuration register holds the word size and a 5-bit prescale code. Writing the transmit register starts a full-duplex exchange in SPI mode 0.

When the exchange ends, the block raises a completion flag that software polls and clears. The word captured from the slave is then read from the receive register. The serial clock is always the system clock divided by an even ratio between 4 and 30. No queueing of words is done: one word is in flight at any time.

Top module: `spiw_top`

## Requirements
- R1: After reset, the chip select (`csN`, active low) is high, `sclk` is low, and the control, configuration and cause registers all read 0. Register offsets: control 0x00, configuration 0x04, transmit 0x08, receive 0x0C, cause 0x10.
- R2: Control bit 0 selects the slave. Writing 1 drives `csN` low on the next cycle, and writing 0 drives it high. The bit reads back at control bit 0.
- R3: Configuration bits [4:0] (prescale code), bit 5 (1 = 16-bit words, 0 = 8-bit words) and bit 14 (timing-adjust option) are stored and read back. All other configuration bits read 0.
- R4: The divide ratio is 2×(code−0x10) for codes 0x12..0x1F, and 4 for any code below 0x12. `sclk` stays high for ratio/2 system cycles and low for ratio/2 system cycles. An exchange ends on its last falling `sclk` edge, W×ratio cycles after the clock edge that accepts the transmit write.
- R5: In 8-bit mode, a transmit write sends bits [7:0] of the written data on `mosi`, MSB first, over 8 `sclk` pulses.
- R6: In 16-bit mode, a transmit write sends bits [15:0] of the written data on `mosi`, MSB first, over 16 `sclk` pulses.
- R7: After completion, the receive register holds the bits sampled from `miso` on the rising edges, MSB first, in its low 8 or 16 bits. All upper bits read 0.
- R8: The cause register reads 1 once an exchange has completed. A write of 0 clears it. A write of any nonzero value leaves it unchanged.
- R9: Mode 0 only. `sclk` is low whenever no exchange is running. `mosi` changes only on falling `sclk` edges (or at launch), so it is stable at every rising edge.
- R10: While an exchange is running, control bit 1 reads 1. A transmit write during that time is ignored: the exchange in flight and its received word are unaffected. Bit 1 reads 0 when the block is idle.
- R11: If a clear of the cause register and the completion of an exchange land on the same clock edge, the cause register ends up set.
- R12: Every bus request is acknowledged on the following cycle. Read data is valid while the acknowledge is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Bus request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with ack |
| ack | output | 1 | Acknowledge, one cycle after req |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| csN | output | 1 | Chip select to the slave, active low |

## Verification
Two events can fall on the same clock edge: the end of an exchange, which sets the cause flag, and a software write of zero to the cause register, which clears it. The bench times a clear so that its accepting edge is exactly the W×ratio-th edge after the launch. It then reads the cause register and expects it to still be set. A second collision is a transmit write issued while the shift engine is busy. This is judged by the slave-side scoreboard, which must see only the first word's bits, and by the unchanged received word.

// File: rtl/spiw_pkg.sv
package spiw_pkg;
  localparam logic [4:0] OFF_CTRL  = 5'h00;
  localparam logic [4:0] OFF_CFG   = 5'h04;
  localparam logic [4:0] OFF_TXD   = 5'h08;
  localparam logic [4:0] OFF_RXD   = 5'h0C;
  localparam logic [4:0] OFF_CAUSE = 5'h10;

  typedef struct packed {
    logic load;    // capture a new transmit word
    logic wide;    // word size at load: 1 = 16 bits
    logic shift;   // falling edge: present next bit
    logic sample;  // rising edge: capture miso
  } dpStrobe_t;
endpackage

// File: rtl/spiw_ctrl.sv
module spiw_ctrl
  import spiw_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ack,
  input  logic [WORD_W-1:0] rxWord,
  output logic              sclk,
  output logic              csN,
  output logic              busy,
  output logic              cause,
  output dpStrobe_t         stb
);
  localparam int HALF_W = 4;
  localparam int BIT_W  = $clog2(WORD_W);

  logic              csSel, cfgWide, cfgAdj, wideLat;
  logic [4:0]        cfgPresc;
  logic [HALF_W-1:0] halfLat, halfCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              busyQ, causeQ, sclkQ, ackQ;
  logic [DATA_W-1:0] rdataQ;
  logic              wrEn, txGo, edgeEv, riseEv, fallEv, lastBit, doneEv, clrEv;
  logic [DATA_W-1:0] rdMux;

  function automatic logic [HALF_W-1:0] halfOf(input logic [4:0] code);
    if (code < 5'h12) return HALF_W'(2);
    else              return HALF_W'(code - 5'h10);
  endfunction

  always_comb begin
    wrEn    = req && we;
    txGo    = wrEn && (addr == OFF_TXD) && !busyQ;
    clrEv   = wrEn && (addr == OFF_CAUSE) && (wdata == '0);
    edgeEv  = busyQ && (halfCnt == halfLat - HALF_W'(1));
    riseEv  = edgeEv && !sclkQ;
    fallEv  = edgeEv && sclkQ;
    lastBit = (bitCnt == (wideLat ? BIT_W'(WORD_W - 1) : BIT_W'(WORD_W/2 - 1)));
    doneEv  = fallEv && lastBit;
    stb.load   = txGo;
    stb.wide   = cfgWide;
    stb.shift  = fallEv && !lastBit;
    stb.sample = riseEv;
  end

  always_comb begin
    rdMux = '0;
    case (addr)
      OFF_CTRL:  begin rdMux[0] = csSel; rdMux[1] = busyQ; end
      OFF_CFG:   begin rdMux[4:0] = cfgPresc; rdMux[5] = cfgWide; rdMux[14] = cfgAdj; end
      OFF_RXD:   rdMux[WORD_W-1:0] = rxWord;
      OFF_CAUSE: rdMux[0] = causeQ;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csSel <= 1'b0; cfgWide <= 1'b0; cfgAdj <= 1'b0; cfgPresc <= '0;
      busyQ <= 1'b0; causeQ <= 1'b0; sclkQ <= 1'b0; wideLat <= 1'b0;
      halfLat <= HALF_W'(2); halfCnt <= '0; bitCnt <= '0;
      ackQ <= 1'b0; rdataQ <= '0;
    end else begin
      ackQ   <= req;
      rdataQ <= (req && !we) ? rdMux : '0;
      if (wrEn && addr == OFF_CTRL) csSel <= wdata[0];
      if (wrEn && addr == OFF_CFG) begin
        cfgPresc <= wdata[4:0];
        cfgWide  <= wdata[5];
        cfgAdj   <= wdata[14];
      end
      if (doneEv)     causeQ <= 1'b1;
      else if (clrEv) causeQ <= 1'b0;
      if (txGo) begin
        busyQ   <= 1'b1;
        halfLat <= halfOf(cfgPresc);
        wideLat <= cfgWide;
        halfCnt <= '0;
        bitCnt  <= '0;
        sclkQ   <= 1'b0;
      end else if (busyQ) begin
        if (edgeEv) begin
          halfCnt <= '0;
          if (!sclkQ) sclkQ <= 1'b1;
          else begin
            sclkQ <= 1'b0;
            if (lastBit) busyQ  <= 1'b0;
            else         bitCnt <= bitCnt + BIT_W'(1);
          end
        end else begin
          halfCnt <= halfCnt + HALF_W'(1);
        end
      end
    end
  end

  assign rdata = rdataQ;
  assign ack   = ackQ;
  assign sclk  = sclkQ;
  assign csN   = ~csSel;
  assign busy  = busyQ;
  assign cause = causeQ;
endmodule

// File: rtl/spiw_dp.sv
module spiw_dp
  import spiw_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         stb,
  input  logic [WORD_W-1:0] txIn,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rxWord
);
  localparam int HALF_WORD = WORD_W / 2;

  logic [WORD_W-1:0] txSr, rxSr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txSr <= '0;
      rxSr <= '0;
    end else if (stb.load) begin
      txSr <= stb.wide ? txIn : {txIn[HALF_WORD-1:0], {HALF_WORD{1'b0}}};
      rxSr <= '0;
    end else begin
      if (stb.shift)  txSr <= {txSr[WORD_W-2:0], 1'b0};
      if (stb.sample) rxSr <= {rxSr[WORD_W-2:0], miso};
    end
  end

  assign mosi   = txSr[WORD_W-1];
  assign rxWord = rxSr;
endmodule

// File: rtl/spiw_top.sv
module spiw_top
  import spiw_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ack,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              csN
);
  dpStrobe_t         stb;
  logic [WORD_W-1:0] rxWord;
  logic              busyW, causeW;

  spiw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ack(ack), .rxWord(rxWord), .sclk(sclk), .csN(csN),
    .busy(busyW), .cause(causeW), .stb(stb)
  );

  spiw_dp #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .txIn(wdata[WORD_W-1:0]),
    .miso(miso), .mosi(mosi), .rxWord(rxWord)
  );
endmodule

// File: rtl/spiw_checker.sv
module spiw_checker
  import spiw_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              ack,
  input logic              sclk,
  input logic              mosi,
  input logic              csN,
  input logic              busy,
  input logic              cause
);
  a_r2_cs_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr == OFF_CTRL) |=> (csN == !$past(wdata[0])));

  a_r4_half_min_two: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |=> $stable(sclk));

  a_r8_done_sets_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cause);

  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  a_r9_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(req && we && addr == OFF_CAUSE && wdata == '0)) |-> cause);

  a_r12_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> ack);
endmodule

bind spiw_top spiw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
  .ack(ack), .sclk(sclk), .mosi(mosi), .csN(csN), .busy(busyW), .cause(causeW)
);

// File: tb/spiw_top_tb_top.sv
module spiw_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack, sclk, mosi, miso, csN;

  int total = 0;
  int bad = 0;

  typedef struct { int w; logic [15:0] word; } exp_t;
  exp_t sbq[$];

  logic [15:0] slvWord = '0;
  int          slvIdx = -1;

  always #2 clk = ~clk;

  spiw_top dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ack(ack), .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN)
  );

  assign miso = (slvIdx >= 0) ? slvWord[slvIdx] : 1'b0;
  always @(negedge sclk) if (slvIdx >= 0) slvIdx <= slvIdx - 1;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
    d = rdata;
    chk(ack, "R12 ack", {31'b0, ack}, 32'h1);
  endtask

  task automatic launch(input logic [15:0] word, input int w, input logic [15:0] slave);
    exp_t e;
    e.w = w; e.word = (w == 8) ? {8'h0, word[7:0]} : word;
    slvWord = slave; slvIdx = w - 1;
    sbq.push_back(e);
    busWrite(5'h08, {16'h0, word});
  endtask

  task automatic waitDone();
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 2000 && v == 0; i++) busRead(5'h10, v);
  endtask

  task automatic measureHigh(input int half, input string tag);
    int cnt;
    @(posedge sclk);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (sclk);
    chk((cnt - 1) == half, tag, cnt - 1, half);
  endtask

  // monitor: collects mosi bits at rising sclk, compares against the scoreboard
  initial begin
    logic [15:0] cap;
    int nb;
    cap = '0; nb = 0;
    forever begin
      @(posedge sclk);
      if (sbq.size() == 0) begin
        total++; bad++;
        $display("FAIL R10 unexpected sclk pulse actual=1 expected=0");
      end else begin
        cap = {cap[14:0], mosi};
        nb++;
        if (nb == sbq[0].w) begin
          exp_t e;
          e = sbq.pop_front();
          chk(cap == e.word, (e.w == 8) ? "R5 mosi word" : "R6 mosi word", {16'h0, cap}, {16'h0, e.word});
          cap = '0; nb = 0;
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(csN == 1'b1, "R1 csN", {31'b0, csN}, 32'h1);
    chk(sclk == 1'b0, "R1 sclk", {31'b0, sclk}, 32'h0);
    busRead(5'h00, v); chk(v == 0, "R1 ctrl", v, 0);
    busRead(5'h04, v); chk(v == 0, "R1 cfg", v, 0);
    busRead(5'h10, v); chk(v == 0, "R1 cause", v, 0);
    // R2 chip select
    busWrite(5'h00, 32'h1);
    chk(csN == 1'b0, "R2 csN low", {31'b0, csN}, 0);
    busRead(5'h00, v); chk(v == 32'h1, "R2 ctrl readback", v, 32'h1);
    // R3 configuration readback
    busWrite(5'h04, 32'hFFFF_FFFF);
    busRead(5'h04, v); chk(v == 32'h403F, "R3 cfg mask", v, 32'h403F);
    // R4 R5 R7 R8: 8-bit, ratio 4
    busWrite(5'h04, 32'h12);
    launch(16'h00A5, 8, 16'h003C);
    measureHigh(2, "R4 ratio4 high");
    waitDone();
    busRead(5'h0C, v); chk(v == 32'h3C, "R7 rx 8-bit", v, 32'h3C);
    busRead(5'h10, v); chk(v == 32'h1, "R8 cause set", v, 1);
    busWrite(5'h10, 32'h5);
    busRead(5'h10, v); chk(v == 32'h1, "R8 nonzero write keeps", v, 1);
    busWrite(5'h10, 32'h0);
    busRead(5'h10, v); chk(v == 32'h0, "R8 zero write clears", v, 0);
    // R6 R4: 16-bit, ratio 30
    busWrite(5'h04, 32'h3F);
    launch(16'hBEEF, 16, 16'h1234);
    measureHigh(15, "R4 ratio30 high");
    waitDone();
    busRead(5'h0C, v); chk(v == 32'h1234, "R7 rx 16-bit", v, 32'h1234);
    busWrite(5'h10, 32'h0);
    // R4 low code maps to ratio 4; R7 upper bits zero
    busWrite(5'h04, 32'h05);
    launch(16'h0081, 8, 16'h00FF);
    measureHigh(2, "R4 low code high");
    waitDone();
    busRead(5'h0C, v); chk(v == 32'hFF, "R7 upper bits zero", v, 32'hFF);
    busWrite(5'h10, 32'h0);
    // R4 ratio 10
    busWrite(5'h04, 32'h15);
    launch(16'h00C9, 8, 16'h0096);
    measureHigh(5, "R4 ratio10 high");
    waitDone();
    busRead(5'h0C, v); chk(v == 32'h96, "R7 rx ratio10", v, 32'h96);
    busWrite(5'h10, 32'h0);
    // R10 busy flag and ignored transmit write
    busWrite(5'h04, 32'h32);
    launch(16'h5AC3, 16, 16'hC35A);
    busRead(5'h00, v); chk(v == 32'h3, "R10 busy set", v, 32'h3);
    busWrite(5'h08, 32'hFFFF);
    waitDone();
    busRead(5'h0C, v); chk(v == 32'hC35A, "R10 rx unaffected", v, 32'hC35A);
    busRead(5'h00, v); chk(v == 32'h1, "R10 busy clear", v, 32'h1);
    chk(sclk == 1'b0, "R9 sclk idle low", {31'b0, sclk}, 0);
    busWrite(5'h10, 32'h0);
    // R11: clear lands on completion edge (8 bits x ratio 4 = 32 cycles)
    busWrite(5'h04, 32'h12);
    launch(16'h0077, 8, 16'h0011);
    repeat (30) @(negedge clk);
    busWrite(5'h10, 32'h0);
    busRead(5'h10, v); chk(v == 32'h1, "R11 set wins over clear", v, 1);
    busRead(5'h0C, v); chk(v == 32'h11, "R7 rx after collision", v, 32'h11);
    // R2 deselect
    busWrite(5'h00, 32'h0);
    chk(csN == 1'b1, "R2 csN high", {31'b0, csN}, 32'h1);
    repeat (20) @(negedge clk);
    chk(sbq.size() == 0, "R5 scoreboard drained", sbq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule